// File: doc/BRIEF.md
# Phase-Frequency Detector with Anti-Backlash Overlap

This block compares a divided reference clock with a divided oscillator clock. It produces the pump-up and pump-down commands for a charge pump. Both inputs are sampled by a fast timing clock. A rising edge on the reference sets the pump-up flop, and a rising edge on the oscillator sets the pump-down flop. A flop stays set until the other input catches up, so the detector responds to a frequency difference as well as to a phase difference. When both flops are set, their common clear is held back for a programmable number of timing-clock cycles. This makes both commands overlap briefly, so even a near-zero phase error gives pulses the pump can act on.

A polarity bit exchanges the two commands for oscillators with a negative tuning slope. A 3-bit pump-current code is registered and passed through to the pump. A standby input forces both commands low and empties the detector. It has a light variant that keeps passing the current code and a deep variant that also forces the code to zero. A zero-phase restart input empties the detector so that tracking starts again from zero phase difference after the divider ratios change.

Top module: `pfd_core`

## Requirements
- R1: While `rstN` is low, `upOut`, `dnOut` and `cpModeOut` are all 0.
- R2: A rising edge on `refIn` sampled at a clock edge makes the pump-up command high from that edge on. The command stays high through any further reference edges until an oscillator edge arrives.
- R3: A rising edge on `vcoIn` sampled at a clock edge makes the pump-down command high from that edge on. The command stays high until a reference edge arrives.
- R4: Once both flops are set, both commands stay high together for exactly N cycles and then both fall. N is 1, 2, 4 or 8 for `abSel` = 0, 1, 2, 3. If the reference leads by d cycles, pump-up is high for d+N cycles and pump-down for N cycles, and the reverse holds when the oscillator leads.
- R5: With `invertPol` = 1, the pump-up command appears on `dnOut` and the pump-down command appears on `upOut`.
- R6: Outside deep standby, `cpModeOut` equals the `cpModeIn` value sampled at the previous clock edge.
- R7: While `standbyEn` is 1, `upOut` and `dnOut` are 0. Input edges seen during standby are discarded, so after release both outputs stay 0 until a new edge arrives.
- R8: Deep standby (`standbyEn` = 1 with `sbDeep` = 1) drives `cpModeOut` to 0 from the next edge on. Light standby (`sbDeep` = 0) leaves the code passing.
- R9: A cycle with `zeroRestart` = 1 clears both flops and discards any input edge sampled in that cycle, so both outputs are 0 after that edge.
- R10: Rising edges on both inputs sampled at the same clock edge make both commands high for exactly N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast timing clock |
| rstN | input | 1 | Asynchronous reset, active low |
| refIn | input | 1 | Divided reference clock |
| vcoIn | input | 1 | Divided oscillator clock |
| abSel | input | 2 | Overlap width select, N = 2^abSel cycles |
| invertPol | input | 1 | Exchanges the pump-up and pump-down outputs |
| cpModeIn | input | 3 | Pump current code |
| standbyEn | input | 1 | Standby request |
| sbDeep | input | 1 | Standby variant: 1 = deep, 0 = light |
| zeroRestart | input | 1 | Clears the phase state for a restart |
| upOut | output | 1 | Pump-up command |
| dnOut | output | 1 | Pump-down command |
| cpModeOut | output | 3 | Registered pump current code |

## Verification
The overlap-length property assumes that `abSel` does not change while both commands are high. The bench changes the width select only after both inputs have returned low and the detector has idled. The properties also assume that both divided clocks are low at reset and stay at each level for at least one timing-clock cycle. The stimulus drives every input one nanosecond after a rising clock edge and holds each level for whole cycles, so the detector never sees a glitch or a change between edges.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  // Channel index of each divided clock in the edge detector vector.
  localparam int CH_REF = 0;
  localparam int CH_VCO = 1;
  localparam int NUM_CH = 2;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic setUp;     // reference edge seen, set pump-up flop
    logic setDn;     // oscillator edge seen, set pump-down flop
    logic clrPhase;  // overlap window complete, clear both flops
    logic flush;     // standby or restart, empty the detector
  } pfdStrobe_t;

endpackage

// File: rtl/pfd_ctrl.sv
module pfd_ctrl
  import pfd_pkg::*;
#(
  parameter int AB_SEL_W = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                refIn,
  input  logic                vcoIn,
  input  logic [AB_SEL_W-1:0] abSel,
  input  logic                standbyEn,
  input  logic                zeroRestart,
  input  logic                bothHigh,
  output pfdStrobe_t          strobe
);

  localparam int MAX_SEL = (1 << AB_SEL_W) - 1;
  localparam int CNT_W   = MAX_SEL + 1;

  logic [NUM_CH-1:0] chIn;
  logic [NUM_CH-1:0] chRise;
  logic              flush;
  logic [CNT_W-1:0]  ovlCnt;
  logic [CNT_W-1:0]  abLast;
  logic              ovlDone;

  assign chIn[CH_REF] = refIn;
  assign chIn[CH_VCO] = vcoIn;

  // One rising-edge detector per divided clock. The history runs in every
  // mode, so an input that is already high on leaving standby gives no edge.
  for (genvar g = 0; g < NUM_CH; g++) begin : g_edge
    logic prevLvl;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) prevLvl <= 1'b0;
      else       prevLvl <= chIn[g];
    end
    assign chRise[g] = chIn[g] & ~prevLvl;
  end

  assign flush   = standbyEn | zeroRestart;
  assign abLast  = (CNT_W'(1) << abSel) - CNT_W'(1);
  assign ovlDone = bothHigh & (ovlCnt == abLast);

  // Count the cycles in which both flops are set.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovlCnt <= '0;
    end else if (flush || !bothHigh || ovlDone) begin
      ovlCnt <= '0;
    end else begin
      ovlCnt <= ovlCnt + CNT_W'(1);
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.flush    = flush;
    strobe.setUp    = chRise[CH_REF] & ~flush;
    strobe.setDn    = chRise[CH_VCO] & ~flush;
    strobe.clrPhase = ovlDone;
  end

endmodule

// File: rtl/pfd_datapath.sv
module pfd_datapath
  import pfd_pkg::*;
#(
  parameter int CP_MODE_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pfdStrobe_t           strobe,
  input  logic                 invertPol,
  input  logic                 standbyEn,
  input  logic                 sbDeep,
  input  logic [CP_MODE_W-1:0] cpModeIn,
  output logic                 upOut,
  output logic                 dnOut,
  output logic [CP_MODE_W-1:0] cpModeOut,
  output logic                 bothHigh
);

  logic upQ;
  logic dnQ;
  logic upNext;
  logic dnNext;
  logic upCmd;
  logic dnCmd;

  // A new edge wins over the overlap clear, so phase information that
  // arrives in the clearing cycle is kept. A flush wins over everything.
  always_comb begin
    if (strobe.flush) begin
      upNext = 1'b0;
      dnNext = 1'b0;
    end else begin
      upNext = strobe.setUp | (upQ & ~strobe.clrPhase);
      dnNext = strobe.setDn | (dnQ & ~strobe.clrPhase);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upQ <= 1'b0;
      dnQ <= 1'b0;
    end else begin
      upQ <= upNext;
      dnQ <= dnNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    cpModeOut <= '0;
    else if (standbyEn && sbDeep) cpModeOut <= '0;
    else                          cpModeOut <= cpModeIn;
  end

  assign bothHigh = upQ & dnQ;
  assign upCmd    = invertPol ? dnQ : upQ;
  assign dnCmd    = invertPol ? upQ : dnQ;
  assign upOut    = upCmd & ~standbyEn;
  assign dnOut    = dnCmd & ~standbyEn;

endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_pkg::*;
#(
  parameter int AB_SEL_W  = 2,
  parameter int CP_MODE_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 refIn,
  input  logic                 vcoIn,
  input  logic [AB_SEL_W-1:0]  abSel,
  input  logic                 invertPol,
  input  logic [CP_MODE_W-1:0] cpModeIn,
  input  logic                 standbyEn,
  input  logic                 sbDeep,
  input  logic                 zeroRestart,
  output logic                 upOut,
  output logic                 dnOut,
  output logic [CP_MODE_W-1:0] cpModeOut
);

  pfdStrobe_t strobe;
  logic       bothHigh;

  pfd_ctrl #(.AB_SEL_W(AB_SEL_W)) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .refIn       (refIn),
    .vcoIn       (vcoIn),
    .abSel       (abSel),
    .standbyEn   (standbyEn),
    .zeroRestart (zeroRestart),
    .bothHigh    (bothHigh),
    .strobe      (strobe)
  );

  pfd_datapath #(.CP_MODE_W(CP_MODE_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .invertPol (invertPol),
    .standbyEn (standbyEn),
    .sbDeep    (sbDeep),
    .cpModeIn  (cpModeIn),
    .upOut     (upOut),
    .dnOut     (dnOut),
    .cpModeOut (cpModeOut),
    .bothHigh  (bothHigh)
  );

endmodule

// File: rtl/pfd_core_chk.sv
module pfd_core_chk #(
  parameter int AB_SEL_W  = 2,
  parameter int CP_MODE_W = 3
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [AB_SEL_W-1:0]  abSel,
  input logic [CP_MODE_W-1:0] cpModeIn,
  input logic                 standbyEn,
  input logic                 sbDeep,
  input logic                 zeroRestart,
  input logic                 upOut,
  input logic                 dnOut,
  input logic [CP_MODE_W-1:0] cpModeOut
);

  localparam int RUN_W = (1 << AB_SEL_W) + 2;

  logic [RUN_W-1:0] runCnt;
  logic [RUN_W-1:0] runLim;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                runCnt <= '0;
    else if (upOut && dnOut)  runCnt <= runCnt + RUN_W'(1);
    else                      runCnt <= '0;
  end

  assign runLim = RUN_W'(1) << abSel;

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    !rstN |-> (!upOut && !dnOut && cpModeOut == '0));

  // R4
  overlap_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    runCnt <= runLim);

  // R6
  mode_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !($past(standbyEn) && $past(sbDeep)))
      |-> cpModeOut == $past(cpModeIn));

  // R7
  standby_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $fell(standbyEn)) |-> (!upOut && !dnOut));

  // R8
  deep_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(standbyEn) && $past(sbDeep)) |-> cpModeOut == '0);

  // R9
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(zeroRestart)) |-> (!upOut && !dnOut));

endmodule

bind pfd_core pfd_core_chk #(.AB_SEL_W(AB_SEL_W), .CP_MODE_W(CP_MODE_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .abSel       (abSel),
  .cpModeIn    (cpModeIn),
  .standbyEn   (standbyEn),
  .sbDeep      (sbDeep),
  .zeroRestart (zeroRestart),
  .upOut       (upOut),
  .dnOut       (dnOut),
  .cpModeOut   (cpModeOut)
);

// File: tb/pfd_core_tb.sv
`timescale 1ns/1ps
module pfd_core_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refIn = 1'b0;
  logic       vcoIn = 1'b0;
  logic [1:0] abSel = 2'd0;
  logic       invertPol = 1'b0;
  logic [2:0] cpModeIn = 3'd0;
  logic       standbyEn = 1'b0;
  logic       sbDeep = 1'b0;
  logic       zeroRestart = 1'b0;
  logic       upOut;
  logic       dnOut;
  logic [2:0] cpModeOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  pfd_core dut_i (
    .clk(clk), .rstN(rstN), .refIn(refIn), .vcoIn(vcoIn), .abSel(abSel),
    .invertPol(invertPol), .cpModeIn(cpModeIn), .standbyEn(standbyEn),
    .sbDeep(sbDeep), .zeroRestart(zeroRestart), .upOut(upOut),
    .dnOut(dnOut), .cpModeOut(cpModeOut)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    refIn = 1'b0;
    vcoIn = 1'b0;
    for (int i = 0; i < n; i++) tick();
  endtask

  // Raise ref at step refAt and vco at step vcoAt, count high samples.
  task automatic runEdges(input int refAt, input int vcoAt, input int win,
                          output int upN, output int dnN);
    upN = 0;
    dnN = 0;
    for (int s = 0; s < win; s++) begin
      refIn = (s >= refAt);
      vcoIn = (s >= vcoAt);
      tick();
      upN += int'(upOut);
      dnN += int'(dnOut);
    end
    idle(3);
  endtask

  task automatic test_reset();
    chk("R1", "upOut in reset", int'(upOut), 0);
    chk("R1", "dnOut in reset", int'(dnOut), 0);
    chk("R1", "cpModeOut in reset", int'(cpModeOut), 0);
  endtask

  task automatic test_ref_lead();
    int u, d;
    for (int sel = 0; sel < 4; sel++) begin
      abSel = 2'(sel);
      for (int lead = 1; lead <= 5; lead += 4) begin
        runEdges(0, lead, 24, u, d);
        chk("R2", $sformatf("ref lead %0d sel %0d up", lead, sel), u, lead + (1 << sel));
        chk("R4", $sformatf("ref lead %0d sel %0d dn", lead, sel), d, 1 << sel);
      end
    end
  endtask

  task automatic test_vco_lead();
    int u, d;
    for (int sel = 0; sel < 4; sel += 3) begin
      abSel = 2'(sel);
      runEdges(3, 0, 24, u, d);
      chk("R3", $sformatf("vco lead sel %0d dn", sel), d, 3 + (1 << sel));
      chk("R4", $sformatf("vco lead sel %0d up", sel), u, 1 << sel);
    end
  endtask

  task automatic test_same_edge();
    int u, d;
    for (int sel = 0; sel < 4; sel++) begin
      abSel = 2'(sel);
      runEdges(0, 0, 20, u, d);
      chk("R10", $sformatf("same edge sel %0d up", sel), u, 1 << sel);
      chk("R10", $sformatf("same edge sel %0d dn", sel), d, 1 << sel);
    end
  endtask

  task automatic test_polarity();
    int u, d;
    abSel = 2'd1;
    invertPol = 1'b1;
    runEdges(0, 2, 16, u, d);
    chk("R5", "inverted up count", u, 2);
    chk("R5", "inverted dn count", d, 4);
    invertPol = 1'b0;
    idle(2);
  endtask

  task automatic test_freq();
    int u;
    abSel = 2'd0;
    u = 0;
    // Two reference edges before any oscillator edge.
    for (int s = 0; s < 8; s++) begin
      refIn = (s < 2 || s >= 4);
      tick();
      u += int'(upOut);
      if (s == 7) chk("R2", "dn idle during freq run", int'(dnOut), 0);
    end
    chk("R2", "up held across ref edges", u, 8);
    vcoIn = 1'b1;
    tick();
    chk("R4", "overlap after freq run", int'(upOut & dnOut), 1);
    tick();
    chk("R4", "cleared after freq run", int'(upOut | dnOut), 0);
    idle(3);
  endtask

  task automatic test_cp_mode();
    for (int m = 0; m < 8; m += 3) begin
      cpModeIn = 3'(m);
      tick();
      chk("R6", $sformatf("cp code %0d", m), int'(cpModeOut), m);
    end
  endtask

  task automatic test_standby();
    abSel = 2'd0;
    cpModeIn = 3'd5;
    refIn = 1'b1;
    tick();
    chk("R2", "up before standby", int'(upOut), 1);
    standbyEn = 1'b1;
    sbDeep = 1'b0;
    #0.5;
    chk("R7", "up gated in standby", int'(upOut), 0);
    tick();
    vcoIn = 1'b1;
    tick();
    chk("R7", "dn low in standby", int'(dnOut), 0);
    chk("R8", "light standby code", int'(cpModeOut), 5);
    standbyEn = 1'b0;
    tick();
    chk("R7", "up after release", int'(upOut), 0);
    tick();
    chk("R7", "dn after release", int'(dnOut), 0);
    idle(2);
    standbyEn = 1'b1;
    sbDeep = 1'b1;
    tick();
    chk("R8", "deep standby code", int'(cpModeOut), 0);
    standbyEn = 1'b0;
    sbDeep = 1'b0;
    tick();
    chk("R6", "code after deep exit", int'(cpModeOut), 5);
    idle(2);
  endtask

  task automatic test_restart();
    int u, d;
    abSel = 2'd2;
    refIn = 1'b1;
    tick();
    tick();
    chk("R2", "up before restart", int'(upOut), 1);
    zeroRestart = 1'b1;
    vcoIn = 1'b1;
    tick();
    chk("R9", "up after restart", int'(upOut), 0);
    chk("R9", "dn after restart", int'(dnOut), 0);
    zeroRestart = 1'b0;
    tick();
    chk("R9", "edge in restart cycle dropped", int'(dnOut), 0);
    idle(2);
    runEdges(0, 0, 16, u, d);
    chk("R9", "fresh up after restart", u, 4);
    chk("R9", "fresh dn after restart", d, 4);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    repeat (3) tick();
    test_reset();
    rstN = 1'b1;
    idle(2);
    test_ref_lead();
    test_vco_lead();
    test_same_edge();
    test_polarity();
    test_freq();
    test_cp_mode();
    test_standby();
    test_restart();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule